// File: doc/BRIEF.md
# Execute-Stage Branch Resolver

This block decides control flow for a pipelined processor while a branch sits in the execute stage. It handles three branch kinds: an unconditional jump, a jump taken when a register operand is zero, and a jump taken when that operand is non-zero. The register operand it receives has already passed through the forwarding network, so the test sees the newest value and not a stale register-file read. The block always produces the branch target, which is the branch's own PC plus its sign-extended word offset scaled by four.

When the branch is taken, the block raises the PC-source select in the same cycle, so the PC register loads the target at the next edge. It also raises two flush strobes. These clear the fetch/decode instruction and the decode/execute control fields, which turns the two wrong-path instructions behind the branch into no-ops. When the branch is not taken, the select stays low and fetch carries on at PC+4.

After a taken branch, the instruction that enters execute on the next cycle is a squashed slot, so the block disregards any branch flags it carries for that one cycle.

Top module: `br_resolve_ex`

## Requirements
- R1: With `br_always` high and no squash cycle in force, the branch is taken whatever the operand value.
- R2: With `br_if_zero` high (and `br_always` low), the branch is taken exactly when `operand` equals zero.
- R3: With `br_if_nonzero` high (and both other flags low), the branch is taken exactly when `operand` is not zero. Priority among the flags is `br_always`, then `br_if_zero`, then `br_if_nonzero`.
- R4: `target_pc` always equals `ex_pc + (ex_offset << 2)`, taken modulo 2^64, in the same cycle as its inputs.
- R5: `pc_sel_target` is 1 in the cycle the branch is taken and 0 when it is not taken. A value of 0 selects PC+4.
- R6: `flush_fetch` and `flush_decode` are both high in exactly the cycles where `pc_sel_target` is high.
- R7: In the clock cycle right after a taken branch, all branch flags are ignored: no select and no flush are produced.
- R8: While `rst_n` is low, the select and both flushes are 0. The first cycle after reset resolves branches normally.
- R9: With no branch flag set, nothing is taken and nothing is flushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| br_always | input | 1 | Unconditional branch flag from decode/execute |
| br_if_zero | input | 1 | Branch-if-zero flag |
| br_if_nonzero | input | 1 | Branch-if-non-zero flag |
| operand | input | 64 | Forwarded register operand under test |
| ex_pc | input | 64 | PC of the instruction in execute |
| ex_offset | input | 64 | Sign-extended word offset |
| target_pc | output | 64 | Computed branch target |
| pc_sel_target | output | 1 | 1: PC loads `target_pc`; 0: PC+4 |
| flush_fetch | output | 1 | Clear the fetch/decode instruction |
| flush_decode | output | 1 | Zero the decode/execute control fields |

## Verification
The target, the select and both flushes are combinational, so they are due in the same cycle the inputs are applied. The bench drives inputs on the falling edge and samples one time unit later, well before the next rising edge. The squash cycle is the only state in the block: a taken branch changes the behaviour one rising edge later. The bench model therefore updates its own squash flag at each rising edge and uses it when it judges the next sampled cycle. Random flag, operand and offset mixes are combined with directed cases: zero and all-ones operands, negative offsets, back-to-back taken branches, and reset.

// File: rtl/br_pkg.sv
// Package: shared branch kind encoding for the execute-stage resolver.
// Assumes at most one meaningful kind per instruction; priority handled by decoder.
package br_pkg;
    typedef enum logic [1:0] {
        BK_NONE    = 2'd0,
        BK_ALWAYS  = 2'd1,
        BK_ZERO    = 2'd2,
        BK_NONZERO = 2'd3
    } br_kind_e;
endpackage

// File: rtl/br_cond_eval.sv
// Module: decodes the branch flags into one kind (always > zero > nonzero)
// and evaluates the condition on the forwarded operand.
// Assumes operand is already forwarded; purely combinational.
module br_cond_eval
    import br_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            f_always,
    input  logic            f_zero,
    input  logic            f_nonzero,
    input  logic [XLEN-1:0] opnd,
    output br_kind_e        kind,
    output logic            cond_true
);
    logic is_zero;

    // zero detect on the forwarded operand
    always_comb is_zero = ~|opnd;

    // priority decode of the flags into a single kind
    always_comb begin
        if (f_always)       kind = BK_ALWAYS;
        else if (f_zero)    kind = BK_ZERO;
        else if (f_nonzero) kind = BK_NONZERO;
        else                kind = BK_NONE;
    end

    // condition outcome per kind
    always_comb begin
        unique case (kind)
            BK_ALWAYS:  cond_true = 1'b1;
            BK_ZERO:    cond_true = is_zero;
            BK_NONZERO: cond_true = ~is_zero;
            default:    cond_true = 1'b0;
        endcase
    end
endmodule

// File: rtl/br_target_gen.sv
// Module: computes branch target = pc + (offset << SHIFT), modulo 2^XLEN.
// Assumes offset is already sign-extended to XLEN bits.
module br_target_gen #(
    parameter int XLEN  = 64,
    parameter int SHIFT = 2
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] offset,
    output logic [XLEN-1:0] target
);
    logic [XLEN-1:0] scaled;

    generate
        if (SHIFT == 0) begin : g_noshift
            // no scaling: byte offsets
            always_comb scaled = offset;
        end else begin : g_shift
            // scale word offset to bytes
            always_comb scaled = {offset[XLEN-1-SHIFT:0], {SHIFT{1'b0}}};
        end
    endgenerate

    // target adder
    always_comb target = pc + scaled;
endmodule

// File: rtl/br_resolve_ex.sv
// Module: execute-stage branch resolver. Produces target, PC-source select
// and flush strobes for fetch/decode and decode/execute registers.
// Assumes flushes take effect at the next rising edge, so the cycle after a
// taken branch holds a squashed slot whose flags must be ignored.
module br_resolve_ex
    import br_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int SHIFT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            br_always,
    input  logic            br_if_zero,
    input  logic            br_if_nonzero,
    input  logic [XLEN-1:0] operand,
    input  logic [XLEN-1:0] ex_pc,
    input  logic [XLEN-1:0] ex_offset,
    output logic [XLEN-1:0] target_pc,
    output logic            pc_sel_target,
    output logic            flush_fetch,
    output logic            flush_decode
);
    br_kind_e kind;
    logic     cond_true;
    logic     squash_q;
    logic     taken;

    br_cond_eval #(.XLEN(XLEN)) i_cond (
        .f_always  (br_always),
        .f_zero    (br_if_zero),
        .f_nonzero (br_if_nonzero),
        .opnd      (operand),
        .kind      (kind),
        .cond_true (cond_true)
    );

    br_target_gen #(.XLEN(XLEN), .SHIFT(SHIFT)) i_tgt (
        .pc     (ex_pc),
        .offset (ex_offset),
        .target (target_pc)
    );

    // final decision: gated by reset and by the squash slot
    always_comb taken = rst_n && !squash_q && (kind != BK_NONE) && cond_true;

    // drive select and flush strobes from the decision
    always_comb begin
        pc_sel_target = taken;
        flush_fetch   = taken;
        flush_decode  = taken;
    end

    // remember a taken branch so the next execute slot is treated as a bubble
    always_ff @(posedge clk) begin
        if (!rst_n) squash_q <= 1'b0;
        else        squash_q <= taken;
    end

    AST_UNCOND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (br_always && !squash_q) |-> pc_sel_target);                           // R1
    AST_ZERO_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (br_if_zero && !br_always && operand == '0 && !squash_q) |-> pc_sel_target); // R2
    AST_NONZERO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (br_if_nonzero && !br_if_zero && !br_always && operand == '0) |-> !pc_sel_target); // R3
    AST_TARGET_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        target_pc[SHIFT-1:0] == ex_pc[SHIFT-1:0]);                             // R4
    AST_FLUSH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sel_target |-> (flush_fetch && flush_decode));                      // R6
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sel_target |=> !pc_sel_target);                                     // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_always && !br_if_zero && !br_if_nonzero) |-> !pc_sel_target);    // R9
endmodule

// File: tb/test_br_resolve_ex.sv
module test_br_resolve_ex;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            br_always = 1'b0, br_if_zero = 1'b0, br_if_nonzero = 1'b0;
    logic [XLEN-1:0] operand = '0, ex_pc = '0, ex_offset = '0;
    logic [XLEN-1:0] target_pc;
    logic            pc_sel_target, flush_fetch, flush_decode;

    int n_checks = 0;
    int n_errors = 0;
    bit model_sq = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    br_resolve_ex i_br_resolve_ex (
        .clk(clk), .rst_n(rst_n),
        .br_always(br_always), .br_if_zero(br_if_zero), .br_if_nonzero(br_if_nonzero),
        .operand(operand), .ex_pc(ex_pc), .ex_offset(ex_offset),
        .target_pc(target_pc), .pc_sel_target(pc_sel_target),
        .flush_fetch(flush_fetch), .flush_decode(flush_decode)
    );

    function automatic bit exp_taken(bit sq, bit a, bit z, bit nz, logic [63:0] op);
        if (sq) return 1'b0;
        if (a) return 1'b1;
        if (z) return op == 64'd0;
        if (nz) return op != 64'd0;
        return 1'b0;
    endfunction

    function automatic logic [63:0] exp_target(logic [63:0] pc, logic [63:0] off);
        return pc + (off << 2);
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // drive at negedge, sample 1 unit later, then advance the model at posedge
    task automatic step(bit a, bit z, bit nz, logic [63:0] op, logic [63:0] pc,
                        logic [63:0] off, string req);
        bit t;
        @(negedge clk);
        br_always = a; br_if_zero = z; br_if_nonzero = nz;
        operand = op; ex_pc = pc; ex_offset = off;
        #1;
        t = exp_taken(model_sq, a, z, nz, op);
        check(pc_sel_target === t, req, {63'd0, pc_sel_target}, {63'd0, t});
        check(flush_fetch === t && flush_decode === t, "R6",
              {62'd0, flush_fetch, flush_decode}, {62'd0, t, t});
        check(target_pc === exp_target(pc, off), "R4", target_pc, exp_target(pc, off));
        @(posedge clk);
        model_sq = t;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // R8: reset holds outputs low even with a branch flag up
        @(negedge clk);
        br_always = 1'b1;
        #1;
        check(!pc_sel_target && !flush_fetch && !flush_decode, "R8",
              {61'd0, pc_sel_target, flush_fetch, flush_decode}, 64'd0);
        @(negedge clk);
        br_always = 1'b0;
        rst_n = 1'b1;
        model_sq = 1'b0;
        // R8: first cycle after reset resolves normally
        step(1, 0, 0, 64'd5, 64'h1000, 64'd4, "R8");
        step(0, 0, 0, 64'd0, 64'h2000, 64'd1, "R7");             // squash slot, idle
        step(0, 0, 0, 64'd0, 64'h2000, 64'd1, "R9");
        step(0, 1, 0, 64'd0, 64'h3000, -64'sd3, "R2");           // zero: taken, negative offset
        step(1, 0, 0, 64'd0, 64'h3004, 64'd8, "R7");             // ignored after taken
        step(0, 1, 0, 64'd1, 64'h3008, 64'd2, "R2");             // non-zero: not taken
        step(0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h4000, 64'd7, "R3");
        step(0, 0, 1, 64'd0, 64'h4010, 64'd7, "R3");             // zero operand: skipped after squash
        step(0, 0, 1, 64'd0, 64'h4014, 64'd7, "R3");
        step(0, 1, 1, 64'd0, 64'h5000, 64'd1, "R3");             // priority: zero wins
        step(0, 0, 0, 64'd0, 64'h5004, 64'd1, "R9");
        step(1, 0, 1, 64'd0, 64'hFFFF_FFFF_FFFF_FFF0, 64'd8, "R1"); // wraps
        step(1, 0, 0, 64'd9, 64'h10, 64'd8, "R7");
        step(1, 0, 0, 64'd9, 64'h10, 64'd8, "R1");
        for (int i = 0; i < 400; i++) begin
            logic [63:0] op, pc, off;
            int sel;
            sel = $urandom_range(0, 7);
            op  = ($urandom_range(0, 2) == 0) ? 64'd0 : {$urandom, $urandom};
            pc  = {$urandom, $urandom};
            off = {{40{$urandom_range(0, 1) == 1}}, 24'($urandom)};
            step(sel[0], sel[1], sel[2], op, pc, off, "R5");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule